// File: doc/BRIEF.md
# Word-Oriented Column Repair Vector Engine

This block performs on-the-fly redundancy analysis for an embedded memory that is accessed a whole word at a time. Each clock cycle it receives a fail map with one bit per data bit, produced by the test compare logic, and the row address of the word under test. A single failing word may carry several failing bits. The engine does not store a list of failing addresses. It hands out spare resources as fails arrive, in the order set by a fixed allocation strategy. A spare row captures the failing row address. A spare column is accounted for by ORing the whole fail map into a column repair vector (CRV), which records every data-bit position that needs column replacement.

A fail is skipped when a spare row already holds its row, or when every failing bit is already present in the CRV. A fail that needs a spare after the strategy has run out latches an unrepairable flag. At the end of the test a strobe asks for the verdict. One cycle later the engine reports the memory repairable only if that flag is clear and the CRV holds no more ones than there are spare columns. The spare row addresses and the CRV stay visible as the repair data. An initialize pulse prepares the engine for a new run or a new strategy.

Top module: `wcrv_repair_engine`

## Requirements
- R1: A cycle counts as failing only when `fail_map_i` is nonzero. A zero fail map leaves `crv_o`, `spare_row_vld_o` and the verdict unchanged.
- R2: A failing cycle whose `row_addr_i` equals the address of a valid spare row allocates nothing and leaves `crv_o` unchanged, even if its fail map adds new bits.
- R3: A failing cycle whose fail map has no bit outside the current CRV (`fail_map_i & ~crv_o` is zero) allocates nothing.
- R4: A row allocation stores `row_addr_i` in the lowest-numbered free spare-row slot i. It sets `spare_row_vld_o[i]` and places the address at `spare_row_addr_o[i*ADDR_W +: ADDR_W]`, visible after the next clock edge.
- R5: A column allocation sets `crv_o` to `crv_o | fail_map_i`, visible after the next clock edge.
- R6: `strategy_i` bit k selects the kind of the k-th spare to be allocated, with 1 meaning a row and 0 a column. Each allocation moves on to the next bit.
- R7: A fail that is not skipped latches an internal unrepairable flag when all `N_ROWS+N_COLS` spares are used, or when its strategy bit selects a row while all row slots are full. No allocation happens on that cycle.
- R8: One cycle after `end_test_i`, `done_o` is 1. `repairable_o` is 1 exactly when the unrepairable flag is clear and the number of ones in the CRV is at most `N_COLS`. Both hold until initialization.
- R9: `init_i` clears the CRV, all spare-row valid bits, the allocation pointer, the flag and `done_o`/`repairable_o`. It takes priority over a fail in the same cycle.
- R10: Synchronous active-high `rst` leaves the same cleared state as `init_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Clear analysis state for a new run |
| strategy_i | input | N_ROWS+N_COLS | Allocation order, bit k = kind of k-th spare (1 row, 0 column) |
| fail_map_i | input | WORD_W | Per-bit fail map of the word compared this cycle |
| row_addr_i | input | ADDR_W | Row address of the word compared this cycle |
| end_test_i | input | 1 | End-of-test strobe requesting the verdict |
| done_o | output | 1 | Verdict valid |
| repairable_o | output | 1 | Memory repairable with the allocated spares |
| spare_row_vld_o | output | N_ROWS | Valid bit per spare-row slot |
| spare_row_addr_o | output | N_ROWS*ADDR_W | Spare-row addresses, slot i at bits i*ADDR_W upward |
| crv_o | output | WORD_W | Column repair vector |

## Verification
The bench builds the engine with a 6-bit address, two spare rows, two spare columns and an 8-bit word instead of the default 4. The wider word is what makes the column-then-column-then-row-then-row case reachable: one pattern drives the CRV to five ones, while under column-row-row-column the same pattern leaves two ones and passes. With two rows and two columns the bench can also use up all four spares and hit the exhaustion flag. It can check the popcount limit at exactly two ones, check that a row hit masks a new fail map, and check that initialization wins over a same-cycle fail.

// File: rtl/wcrv_pkg.sv
package wcrv_pkg;

  typedef enum logic {
    SPARE_COL = 1'b0,
    SPARE_ROW = 1'b1
  } spare_kind_e;

endpackage

// File: rtl/wcrv_popcount.sv
module wcrv_popcount #(
  parameter int W     = 4,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CNT_W'(vec_i[i]);
    end
  end

endmodule

// File: rtl/wcrv_row_store.sv
module wcrv_row_store #(
  parameter int ADDR_W = 6,
  parameter int N_ROWS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic                     hit_o,
  output logic                     full_o,
  output logic [N_ROWS-1:0]        vld_o,
  output logic [N_ROWS*ADDR_W-1:0] addr_flat_o
);

  localparam int IDX_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;

  logic [N_ROWS-1:0] vld_q;
  logic [N_ROWS-1:0] hit_vec;
  logic [IDX_W-1:0]  free_idx;
  logic              free_found;

  // lowest free slot
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < N_ROWS; i++) begin
      if (!vld_q[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_ROWS; g++) begin : g_slot
      logic [ADDR_W-1:0] addr_q;

      always_ff @(posedge clk) begin
        if (rst || clear_i) begin
          vld_q[g] <= 1'b0;
        end else if (wr_i && free_found && (free_idx == IDX_W'(g))) begin
          vld_q[g] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (wr_i && free_found && (free_idx == IDX_W'(g))) begin
          addr_q <= addr_i;
        end
      end

      assign hit_vec[g] = vld_q[g] && (addr_q == addr_i);
      assign addr_flat_o[g*ADDR_W +: ADDR_W] = addr_q;
    end
  endgenerate

  assign hit_o  = |hit_vec;
  assign full_o = &vld_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/wcrv_alloc_ctrl.sv
module wcrv_alloc_ctrl
  import wcrv_pkg::*;
#(
  parameter int N_SPARES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init_i,
  input  logic [N_SPARES-1:0] strategy_i,
  input  logic                fail_any_i,
  input  logic                covered_i,
  input  logic                row_hit_i,
  input  logic                rows_full_i,
  output logic                row_wr_o,
  output logic                col_wr_o,
  output logic                flag_o
);

  localparam int PTR_W = $clog2(N_SPARES + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(N_SPARES);

  logic [PTR_W-1:0]    ptr_q;
  logic                flag_q;
  logic [N_SPARES-1:0] strat_shift;
  spare_kind_e         next_kind;
  logic                needs_spare;
  logic                exhausted;
  logic                set_flag;

  assign strat_shift = strategy_i >> ptr_q;
  assign next_kind   = spare_kind_e'(strat_shift[0]);
  assign exhausted   = (ptr_q == PTR_END);
  assign needs_spare = !init_i && fail_any_i && !row_hit_i && !covered_i && !flag_q;

  always_comb begin
    row_wr_o = 1'b0;
    col_wr_o = 1'b0;
    set_flag = 1'b0;
    if (needs_spare) begin
      if (exhausted) begin
        set_flag = 1'b1;
      end else if (next_kind == SPARE_ROW) begin
        if (rows_full_i) set_flag = 1'b1;
        else             row_wr_o = 1'b1;
      end else begin
        col_wr_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      ptr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (row_wr_o || col_wr_o) ptr_q <= ptr_q + 1'b1;
      if (set_flag)             flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/wcrv_repair_engine.sv
module wcrv_repair_engine #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 4,
  parameter int N_ROWS = 2,
  parameter int N_COLS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       init_i,
  input  logic [N_ROWS+N_COLS-1:0]   strategy_i,
  input  logic [WORD_W-1:0]          fail_map_i,
  input  logic [ADDR_W-1:0]          row_addr_i,
  input  logic                       end_test_i,
  output logic                       done_o,
  output logic                       repairable_o,
  output logic [N_ROWS-1:0]          spare_row_vld_o,
  output logic [N_ROWS*ADDR_W-1:0]   spare_row_addr_o,
  output logic [WORD_W-1:0]          crv_o
);

  localparam int N_SPARES = N_ROWS + N_COLS;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] COL_LIMIT = CNT_W'(N_COLS);

  logic [WORD_W-1:0] crv_q;
  logic [CNT_W-1:0]  crv_ones;
  logic              fail_any;
  logic              covered;
  logic              row_hit;
  logic              rows_full;
  logic              row_wr;
  logic              col_wr;
  logic              flag;
  logic              done_q;
  logic              rep_q;

  assign fail_any = |fail_map_i;
  assign covered  = ~|(fail_map_i & ~crv_q);

  wcrv_row_store #(
    .ADDR_W (ADDR_W),
    .N_ROWS (N_ROWS)
  ) u_rows (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (init_i),
    .wr_i        (row_wr),
    .addr_i      (row_addr_i),
    .hit_o       (row_hit),
    .full_o      (rows_full),
    .vld_o       (spare_row_vld_o),
    .addr_flat_o (spare_row_addr_o)
  );

  wcrv_alloc_ctrl #(
    .N_SPARES (N_SPARES)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .init_i      (init_i),
    .strategy_i  (strategy_i),
    .fail_any_i  (fail_any),
    .covered_i   (covered),
    .row_hit_i   (row_hit),
    .rows_full_i (rows_full),
    .row_wr_o    (row_wr),
    .col_wr_o    (col_wr),
    .flag_o      (flag)
  );

  wcrv_popcount #(
    .W     (WORD_W),
    .CNT_W (CNT_W)
  ) u_pop (
    .vec_i (crv_q),
    .cnt_o (crv_ones)
  );

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      crv_q <= '0;
    end else if (col_wr) begin
      crv_q <= crv_q | fail_map_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      done_q <= 1'b0;
      rep_q  <= 1'b0;
    end else if (end_test_i) begin
      done_q <= 1'b1;
      rep_q  <= !flag && (crv_ones <= COL_LIMIT);
    end
  end

  assign crv_o        = crv_q;
  assign done_o       = done_q;
  assign repairable_o = rep_q;

endmodule

// File: rtl/wcrv_repair_engine_chk.sv
module wcrv_repair_engine_chk #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 4,
  parameter int N_ROWS = 2,
  parameter int N_COLS = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     init_i,
  input logic [WORD_W-1:0]        fail_map_i,
  input logic                     end_test_i,
  input logic                     done_o,
  input logic                     repairable_o,
  input logic [N_ROWS-1:0]        spare_row_vld_o,
  input logic [WORD_W-1:0]        crv_o
);

  // R1
  pass_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_map_i == '0 && !init_i) |=> ($stable(crv_o) && $stable(spare_row_vld_o)));

  // R5
  crv_grows_only_chk: assert property (@(posedge clk) disable iff (rst)
    !init_i |=> ((crv_o & $past(crv_o)) == $past(crv_o)));

  // R4
  one_row_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !init_i |=> ($countones(spare_row_vld_o) <= $countones($past(spare_row_vld_o)) + 1));

  // R5
  crv_within_fail_chk: assert property (@(posedge clk) disable iff (rst)
    !init_i |=> ((crv_o & ~$past(crv_o) & ~$past(fail_map_i)) == '0));

  // R8
  verdict_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (end_test_i && !init_i) |=> done_o);

  // R8
  rep_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    repairable_o |-> done_o);

  // R9
  init_clears_chk: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (crv_o == '0 && spare_row_vld_o == '0 && !done_o && !repairable_o));

endmodule

bind wcrv_repair_engine wcrv_repair_engine_chk #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W),
  .N_ROWS (N_ROWS),
  .N_COLS (N_COLS)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .init_i          (init_i),
  .fail_map_i      (fail_map_i),
  .end_test_i      (end_test_i),
  .done_o          (done_o),
  .repairable_o    (repairable_o),
  .spare_row_vld_o (spare_row_vld_o),
  .crv_o           (crv_o)
);

// File: tb/sim_wcrv_repair_engine.sv
`timescale 1ns/1ps
module sim_wcrv_repair_engine;

  localparam int AW = 6;
  localparam int WW = 8;
  localparam int NR = 2;
  localparam int NC = 2;

  typedef struct packed {
    logic          init;
    logic [3:0]    strat;
    logic [WW-1:0] fail;
    logic [AW-1:0] row;
    logic          endt;
    logic [WW-1:0] e_crv;
    logic [NR-1:0] e_vld;
    logic          e_done;
    logic          e_rep;
  } vec_t;

  // strategy bit k = k-th spare, 1 row / 0 column
  localparam logic [3:0] CCRR = 4'b1100;
  localparam logic [3:0] CRRC = 4'b0110;
  localparam logic [3:0] RRCC = 4'b0011;
  localparam int NV = 26;

  localparam vec_t TABLE [NV] = '{
    // CCRR: five ones in CRV -> unrepairable (R5 R3 R8)
    '{1'b1, CCRR, 8'h00, 6'd0, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0},
    '{1'b0, CCRR, 8'h06, 6'd1, 1'b0, 8'h06, 2'b00, 1'b0, 1'b0},
    '{1'b0, CCRR, 8'h38, 6'd2, 1'b0, 8'h3E, 2'b00, 1'b0, 1'b0},
    '{1'b0, CCRR, 8'h38, 6'd2, 1'b0, 8'h3E, 2'b00, 1'b0, 1'b0},
    '{1'b0, CCRR, 8'h02, 6'd5, 1'b0, 8'h3E, 2'b00, 1'b0, 1'b0},
    '{1'b0, CCRR, 8'h00, 6'd0, 1'b1, 8'h3E, 2'b00, 1'b1, 1'b0},
    // CRRC: same pattern -> two ones, repairable (R4 R2 R6)
    '{1'b1, CRRC, 8'h00, 6'd0, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0},
    '{1'b0, CRRC, 8'h06, 6'd1, 1'b0, 8'h06, 2'b00, 1'b0, 1'b0},
    '{1'b0, CRRC, 8'h38, 6'd2, 1'b0, 8'h06, 2'b01, 1'b0, 1'b0},
    '{1'b0, CRRC, 8'h38, 6'd2, 1'b0, 8'h06, 2'b01, 1'b0, 1'b0},
    '{1'b0, CRRC, 8'h02, 6'd5, 1'b0, 8'h06, 2'b01, 1'b0, 1'b0},
    '{1'b0, CRRC, 8'h11, 6'd2, 1'b0, 8'h06, 2'b01, 1'b0, 1'b0},
    '{1'b0, CRRC, 8'h00, 6'd0, 1'b1, 8'h06, 2'b01, 1'b1, 1'b1},
    // RRCC: exhaustion latches flag (R7 R1)
    '{1'b1, RRCC, 8'h00, 6'd0, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0},
    '{1'b0, RRCC, 8'h01, 6'd3, 1'b0, 8'h00, 2'b01, 1'b0, 1'b0},
    '{1'b0, RRCC, 8'h01, 6'd4, 1'b0, 8'h00, 2'b11, 1'b0, 1'b0},
    '{1'b0, RRCC, 8'h80, 6'd6, 1'b0, 8'h80, 2'b11, 1'b0, 1'b0},
    '{1'b0, RRCC, 8'h40, 6'd7, 1'b0, 8'hC0, 2'b11, 1'b0, 1'b0},
    '{1'b0, RRCC, 8'h20, 6'd8, 1'b0, 8'hC0, 2'b11, 1'b0, 1'b0},
    '{1'b0, RRCC, 8'h00, 6'd9, 1'b0, 8'hC0, 2'b11, 1'b0, 1'b0},
    '{1'b0, RRCC, 8'h00, 6'd0, 1'b1, 8'hC0, 2'b11, 1'b1, 1'b0},
    // CCRR: exactly N_COLS ones -> repairable; init beats fail (R8 R9)
    '{1'b1, CCRR, 8'h00, 6'd0, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0},
    '{1'b0, CCRR, 8'h81, 6'd0, 1'b0, 8'h81, 2'b00, 1'b0, 1'b0},
    '{1'b0, CCRR, 8'h00, 6'd0, 1'b1, 8'h81, 2'b00, 1'b1, 1'b1},
    '{1'b1, CCRR, 8'h04, 6'd3, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0},
    '{1'b0, CCRR, 8'h00, 6'd0, 1'b1, 8'h00, 2'b00, 1'b1, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             init_i;
  logic [3:0]       strategy_i;
  logic [WW-1:0]    fail_map_i;
  logic [AW-1:0]    row_addr_i;
  logic             end_test_i;
  logic             done_o;
  logic             repairable_o;
  logic [NR-1:0]    spare_row_vld_o;
  logic [NR*AW-1:0] spare_row_addr_o;
  logic [WW-1:0]    crv_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wcrv_repair_engine #(
    .ADDR_W (AW),
    .WORD_W (WW),
    .N_ROWS (NR),
    .N_COLS (NC)
  ) u0 (
    .clk              (clk),
    .rst              (rst),
    .init_i           (init_i),
    .strategy_i       (strategy_i),
    .fail_map_i       (fail_map_i),
    .row_addr_i       (row_addr_i),
    .end_test_i       (end_test_i),
    .done_o           (done_o),
    .repairable_o     (repairable_o),
    .spare_row_vld_o  (spare_row_vld_o),
    .spare_row_addr_o (spare_row_addr_o),
    .crv_o            (crv_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic in, input logic [3:0] st, input logic [WW-1:0] f,
                       input logic [AW-1:0] r, input logic et);
    init_i     = in;
    strategy_i = st;
    fail_map_i = f;
    row_addr_i = r;
    end_test_i = et;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, CCRR, '0, '0, 1'b0);
    drive(1'b0, CCRR, '0, '0, 1'b0);
    rst = 1'b0;
    // R10 reset state
    check("R10 crv", 32'(crv_o), 32'h0);
    check("R10 vld", 32'(spare_row_vld_o), 32'h0);
    check("R10 done", 32'(done_o), 32'h0);
    check("R10 rep", 32'(repairable_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TABLE[i].init, TABLE[i].strat, TABLE[i].fail, TABLE[i].row, TABLE[i].endt);
      check($sformatf("R1-table crv v%0d", i), 32'(crv_o), 32'(TABLE[i].e_crv));
      check($sformatf("R4 table vld v%0d", i), 32'(spare_row_vld_o), 32'(TABLE[i].e_vld));
      check($sformatf("R8 table done v%0d", i), 32'(done_o), 32'(TABLE[i].e_done));
      check($sformatf("R8 table rep v%0d", i), 32'(repairable_o), 32'(TABLE[i].e_rep));
    end

    // R4 slot order and address placement
    drive(1'b1, RRCC, '0, '0, 1'b0);
    drive(1'b0, RRCC, 8'h01, 6'h2A, 1'b0);
    drive(1'b0, RRCC, 8'h02, 6'h15, 1'b0);
    check("R4 addr", 32'(spare_row_addr_o), 32'({6'h15, 6'h2A}));
    check("R4 vld", 32'(spare_row_vld_o), 32'h3);
    // R6 third spare is a column
    drive(1'b0, RRCC, 8'h10, 6'h01, 1'b0);
    check("R6 col after rows", 32'(crv_o), 32'h10);
    // R7 rows full under row-first strategy with extra row bit
    drive(1'b1, 4'b0111, '0, '0, 1'b0);
    drive(1'b0, 4'b0111, 8'h01, 6'd1, 1'b0);
    drive(1'b0, 4'b0111, 8'h01, 6'd2, 1'b0);
    drive(1'b0, 4'b0111, 8'h01, 6'd3, 1'b0);
    drive(1'b0, 4'b0111, 8'h00, 6'd0, 1'b1);
    check("R7 rows full crv", 32'(crv_o), 32'h0);
    check("R7 rows full rep", 32'(repairable_o), 32'h0);
    // R10 reset mid-run
    rst = 1'b1;
    drive(1'b0, CCRR, 8'h01, 6'd0, 1'b0);
    rst = 1'b0;
    check("R10 mid crv", 32'(crv_o), 32'h0);
    check("R10 mid vld", 32'(spare_row_vld_o), 32'h0);
    check("R10 mid done", 32'(done_o), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule